// File: doc/BRIEF.md
# Chip-Select Rank Resolver with Sparing

The block turns a requested rank number into the chip-select base bits that seed physical-address reconstruction. It holds no table of its own. The memory-controller configuration presents a small table of chip-select entries on its inputs. Each entry carries an identifying number, a base, a mask, a test-fail flag and a rank. Two more inputs give the controller-wide spare and bad chip-select numbers and the chip-select interleave factor.

A start pulse launches a sequential scan that examines one entry per clock. The scan looks for the first entry whose rank equals the request. The matched entry is then screened. An entry that has been substituted by the spare, or that failed power-on test, is not part of the address map, so the block reports a no-address error for it. When the match is the spare chip-select and a bad chip-select is recorded, the block rescans the table for the bad number. It then builds the seed from that entry's base and mask, because the spare answers at the failed entry's addresses.

The seed holds three kinds of base bits:
- the unmaskable bits just above the high mask field;
- the high base bits that the mask leaves uncovered;
- the low base bits that the mask leaves uncovered, but only under chip-select interleaving.

All other seed bits are zero. The table, spare, bad and interleave inputs must be held steady while a scan runs.

Top module: `cs_rank_resolver`

## Requirements
- R1: After start, the first entry in index order (0 upward) whose rank equals the requested rank is selected. The result then takes that entry's base and mask with error code 0, as long as no rule in R3 to R5 applies.
- R2: If no entry's rank matches, done is raised with error code 1 (no address) after all entries have been scanned, and the seed is zero.
- R3: If the matched entry's number equals the bad chip-select number, the result is error code 1 with a zero seed. This rule applies only when the bad number is not the absent value.
- R4: If the matched entry has its test-fail flag set, the result is error code 1 with a zero seed. R3 is checked first and R4 second.
- R5: If the matched entry passes R3 and R4, its number equals the spare number, and both spare and bad numbers are present, the block rescans from index 0. The first entry whose number equals the bad number supplies the base and mask, with error code 0.
- R6: If that rescan finds no entry with the bad number, done is raised with error code 2 (invalid configuration) and a zero seed.
- R7: Seed bits HI_HI down to HI_LO equal base AND NOT mask over that field.
- R8: Seed bits LO_HI down to LO_LO equal base AND NOT mask over that field when the interleave factor is greater than 1. Otherwise these bits are zero.
- R9: The UNMASK_N seed bits directly above HI_HI copy the base unchanged, regardless of the mask. All seed bits outside the fields of R7 to R9 are zero.
- R10: A spare or bad number of all ones means absent. An absent bad number never triggers R3 or R5. An absent spare never triggers R5, even for an entry whose number is all ones.
- R11: The scan examines one entry per clock. Counting clock edges after the one that samples start, done appears at edge m+1 for a match at index m. It appears at edge m+2+b when the rescan finds the bad entry at index b, at edge NUM_CS after a full scan with no match, and at edge m+1+NUM_CS after a failed rescan. Done is a single-cycle pulse, and start is ignored while a scan is running.
- R12: After reset, done, error code and seed are all zero. Error code and seed hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a lookup (sampled when idle) |
| req_rank_i | input | RANK_W | Requested rank |
| spare_cs_i | input | NUM_W | Spare chip-select number, all ones = absent |
| bad_cs_i | input | NUM_W | Substituted (bad) chip-select number, all ones = absent |
| intlv_fctr_i | input | FCTR_W | Chip-select interleave factor |
| cs_num_i | input | NUM_CS*NUM_W | Entry numbers, entry i at bits [i*NUM_W +: NUM_W] |
| cs_base_i | input | NUM_CS*ADDR_W | Entry bases, entry i at [i*ADDR_W +: ADDR_W] |
| cs_mask_i | input | NUM_CS*ADDR_W | Entry masks, entry i at [i*ADDR_W +: ADDR_W] |
| cs_fail_i | input | NUM_CS | Entry test-fail flags, bit i for entry i |
| cs_rank_i | input | NUM_CS*RANK_W | Entry ranks, entry i at [i*RANK_W +: RANK_W] |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 2 | 0 ok, 1 no address, 2 invalid configuration |
| seed_o | output | ADDR_W | Base-derived seed address |

## Verification
The bench uses the default build:
- NUM_CS=8, NUM_W=4, RANK_W=3 and ADDR_W=36.
- A high mask field at bits 29:19, a low field at 13:5 and two unmaskable bits at 31:30.

Eight entries make the worst-case rescan latency of sixteen edges reachable. It also leaves room for duplicate ranks, for a bad entry placed before or after the spare, and for a rescan that misses. A four-bit number field allows an entry numbered 15 to meet the absent value. A three-bit rank lets random requests miss the table. Separated fields expose any leak of masked, gated or out-of-field bits into the seed.

// File: rtl/cs_res_pkg.sv
package cs_res_pkg;
  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NOADDR = 2'd1,
    ERR_BADCFG = 2'd2
  } res_err_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_RESCAN = 2'd2
  } res_state_e;
endpackage

// File: rtl/cs_entry_sel.sv
module cs_entry_sel #(
  parameter int NUM_CS = 8,
  parameter int NUM_W  = 4,
  parameter int RANK_W = 3,
  parameter int ADDR_W = 36,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [NUM_CS*NUM_W-1:0]  cs_num_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_base_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_mask_i,
  input  logic [NUM_CS-1:0]        cs_fail_i,
  input  logic [NUM_CS*RANK_W-1:0] cs_rank_i,
  output logic [NUM_W-1:0]         num_o,
  output logic [ADDR_W-1:0]        base_o,
  output logic [ADDR_W-1:0]        mask_o,
  output logic                     fail_o,
  output logic [RANK_W-1:0]        rank_o
);
  logic [NUM_W-1:0]  num_a  [NUM_CS];
  logic [ADDR_W-1:0] base_a [NUM_CS];
  logic [ADDR_W-1:0] mask_a [NUM_CS];
  logic [RANK_W-1:0] rank_a [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign num_a[g]  = cs_num_i[g*NUM_W +: NUM_W];
    assign base_a[g] = cs_base_i[g*ADDR_W +: ADDR_W];
    assign mask_a[g] = cs_mask_i[g*ADDR_W +: ADDR_W];
    assign rank_a[g] = cs_rank_i[g*RANK_W +: RANK_W];
  end

  assign num_o  = num_a[idx_i];
  assign base_o = base_a[idx_i];
  assign mask_o = mask_a[idx_i];
  assign fail_o = cs_fail_i[idx_i];
  assign rank_o = rank_a[idx_i];
endmodule

// File: rtl/cs_seed_gen.sv
module cs_seed_gen #(
  parameter int ADDR_W   = 36,
  parameter int HI_HI    = 29,
  parameter int HI_LO    = 19,
  parameter int LO_HI    = 13,
  parameter int LO_LO    = 5,
  parameter int UNMASK_N = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              lo_en_i,
  output logic [ADDR_W-1:0] seed_o
);
  localparam int HI_N = HI_HI - HI_LO + 1;
  localparam int LO_N = LO_HI - LO_LO + 1;

  logic [ADDR_W-1:0] hi_part, lo_part, um_part;

  always_comb begin
    hi_part = '0;
    hi_part[HI_HI:HI_LO] = base_i[HI_HI:HI_LO] & ~mask_i[HI_HI:HI_LO];
  end

  always_comb begin
    lo_part = '0;
    if (lo_en_i) lo_part[LO_HI:LO_LO] = base_i[LO_HI:LO_LO] & ~mask_i[LO_HI:LO_LO];
  end

  if (UNMASK_N > 0) begin : g_unmask
    always_comb begin
      um_part = '0;
      um_part[HI_HI+UNMASK_N:HI_HI+1] = base_i[HI_HI+UNMASK_N:HI_HI+1];
    end
  end else begin : g_no_unmask
    assign um_part = '0;
  end

  assign seed_o = hi_part | lo_part | um_part;

  initial begin
    if (HI_N < 1 || LO_N < 1 || HI_LO <= LO_HI || HI_HI + UNMASK_N >= ADDR_W)
      $display("cs_seed_gen: inconsistent field parameters");
  end
endmodule

// File: rtl/cs_scan_fsm.sv
module cs_scan_fsm
  import cs_res_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int NUM_W  = 4,
  parameter int RANK_W = 3,
  parameter int ADDR_W = 36,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RANK_W-1:0] req_rank_i,
  input  logic [NUM_W-1:0]  spare_cs_i,
  input  logic [NUM_W-1:0]  bad_cs_i,
  input  logic [NUM_W-1:0]  ent_num_i,
  input  logic              ent_fail_i,
  input  logic [RANK_W-1:0] ent_rank_i,
  input  logic [ADDR_W-1:0] ent_seed_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [ADDR_W-1:0] seed_o
);
  localparam logic [NUM_W-1:0] ABSENT = '1;
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_CS - 1);

  res_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RANK_W-1:0] rank_q;
  logic              done_q;
  res_err_e          err_q;
  logic [ADDR_W-1:0] seed_q;

  logic     bad_vld, spare_vld, hit, is_bad, is_last;
  logic     fin, to_rescan;
  res_err_e nxt_err;

  assign bad_vld   = (bad_cs_i != ABSENT);
  assign spare_vld = (spare_cs_i != ABSENT);
  assign hit       = (ent_rank_i == rank_q);
  assign is_bad    = bad_vld && (ent_num_i == bad_cs_i);
  assign is_last   = (idx_q == LAST);

  always_comb begin
    fin       = 1'b0;
    to_rescan = 1'b0;
    nxt_err   = ERR_NONE;
    unique case (st_q)
      ST_SCAN: begin
        if (hit) begin
          if (is_bad) begin
            fin = 1'b1; nxt_err = ERR_NOADDR;
          end else if (ent_fail_i) begin
            fin = 1'b1; nxt_err = ERR_NOADDR;
          end else if (spare_vld && bad_vld && ent_num_i == spare_cs_i) begin
            to_rescan = 1'b1;
          end else begin
            fin = 1'b1;
          end
        end else if (is_last) begin
          fin = 1'b1; nxt_err = ERR_NOADDR;
        end
      end
      ST_RESCAN: begin
        if (is_bad) begin
          fin = 1'b1;
        end else if (is_last) begin
          fin = 1'b1; nxt_err = ERR_BADCFG;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      rank_q <= '0;
      done_q <= 1'b0;
      err_q  <= ERR_NONE;
      seed_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_SCAN;
            idx_q  <= '0;
            rank_q <= req_rank_i;
          end
        end
        default: begin
          if (fin) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b1;
            err_q  <= nxt_err;
            seed_q <= (nxt_err == ERR_NONE) ? ent_seed_i : '0;
          end else if (to_rescan) begin
            st_q  <= ST_RESCAN;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign seed_o = seed_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R11
  AST_NO_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !done_q); // R11
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !fin && !to_rescan) |=> (idx_q == $past(idx_q) + 1'b1)); // R11
  AST_BADCFG_FROM_RESCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESCAN && fin) |=> (err_q != ERR_NOADDR)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> (rank_q == $past(rank_q))); // R11
endmodule

// File: rtl/cs_rank_resolver.sv
module cs_rank_resolver
  import cs_res_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int NUM_W    = 4,
  parameter int RANK_W   = 3,
  parameter int ADDR_W   = 36,
  parameter int FCTR_W   = 4,
  parameter int HI_HI    = 29,
  parameter int HI_LO    = 19,
  parameter int LO_HI    = 13,
  parameter int LO_LO    = 5,
  parameter int UNMASK_N = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [RANK_W-1:0]        req_rank_i,
  input  logic [NUM_W-1:0]         spare_cs_i,
  input  logic [NUM_W-1:0]         bad_cs_i,
  input  logic [FCTR_W-1:0]        intlv_fctr_i,
  input  logic [NUM_CS*NUM_W-1:0]  cs_num_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_base_i,
  input  logic [NUM_CS*ADDR_W-1:0] cs_mask_i,
  input  logic [NUM_CS-1:0]        cs_fail_i,
  input  logic [NUM_CS*RANK_W-1:0] cs_rank_i,
  output logic                     done_o,
  output logic [1:0]               err_o,
  output logic [ADDR_W-1:0]        seed_o
);
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [IDX_W-1:0]  idx;
  logic [NUM_W-1:0]  ent_num;
  logic [ADDR_W-1:0] ent_base, ent_mask, ent_seed;
  logic              ent_fail, lo_en;
  logic [RANK_W-1:0] ent_rank;

  assign lo_en = (intlv_fctr_i > FCTR_W'(1));

  cs_entry_sel #(.NUM_CS(NUM_CS), .NUM_W(NUM_W), .RANK_W(RANK_W), .ADDR_W(ADDR_W)) u_sel (
    .idx_i(idx), .cs_num_i(cs_num_i), .cs_base_i(cs_base_i), .cs_mask_i(cs_mask_i),
    .cs_fail_i(cs_fail_i), .cs_rank_i(cs_rank_i), .num_o(ent_num), .base_o(ent_base),
    .mask_o(ent_mask), .fail_o(ent_fail), .rank_o(ent_rank)
  );

  cs_seed_gen #(.ADDR_W(ADDR_W), .HI_HI(HI_HI), .HI_LO(HI_LO), .LO_HI(LO_HI),
                .LO_LO(LO_LO), .UNMASK_N(UNMASK_N)) u_seed (
    .base_i(ent_base), .mask_i(ent_mask), .lo_en_i(lo_en), .seed_o(ent_seed)
  );

  cs_scan_fsm #(.NUM_CS(NUM_CS), .NUM_W(NUM_W), .RANK_W(RANK_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .req_rank_i(req_rank_i),
    .spare_cs_i(spare_cs_i), .bad_cs_i(bad_cs_i), .ent_num_i(ent_num),
    .ent_fail_i(ent_fail), .ent_rank_i(ent_rank), .ent_seed_i(ent_seed),
    .idx_o(idx), .done_o(done_o), .err_o(err_o), .seed_o(seed_o)
  );

  AST_LO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && intlv_fctr_i <= FCTR_W'(1)) |-> (seed_o[LO_HI:LO_LO] == '0)); // R8
  AST_ERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o != 2'd3)); // R2
  AST_QUIET_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seed_o != '0) |-> (err_o == ERR_NONE)); // R3
endmodule

// File: tb/tb_cs_rank_resolver.sv
module tb_cs_rank_resolver;
  localparam int NUM_CS = 8, NUM_W = 4, RANK_W = 3, ADDR_W = 36, FCTR_W = 4;
  localparam int HI_HI = 29, HI_LO = 19, LO_HI = 13, LO_LO = 5, UNMASK_N = 2;
  localparam logic [NUM_W-1:0] ABS = '1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [RANK_W-1:0] req_rank = '0;
  logic [NUM_W-1:0] spare = ABS, bad = ABS;
  logic [FCTR_W-1:0] fctr = '0;
  logic [NUM_CS*NUM_W-1:0]  t_num  = '0;
  logic [NUM_CS*ADDR_W-1:0] t_base = '0, t_mask = '0;
  logic [NUM_CS-1:0]        t_fail = '0;
  logic [NUM_CS*RANK_W-1:0] t_rank = '0;
  logic done;
  logic [1:0] err;
  logic [ADDR_W-1:0] seed;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cs_rank_resolver dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_rank_i(req_rank),
    .spare_cs_i(spare), .bad_cs_i(bad), .intlv_fctr_i(fctr), .cs_num_i(t_num),
    .cs_base_i(t_base), .cs_mask_i(t_mask), .cs_fail_i(t_fail), .cs_rank_i(t_rank),
    .done_o(done), .err_o(err), .seed_o(seed)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input logic [NUM_W-1:0] n, input logic [ADDR_W-1:0] b,
                         input logic [ADDR_W-1:0] m, input logic f, input logic [RANK_W-1:0] r);
    t_num[i*NUM_W +: NUM_W]    = n;
    t_base[i*ADDR_W +: ADDR_W] = b;
    t_mask[i*ADDR_W +: ADDR_W] = m;
    t_fail[i]                  = f;
    t_rank[i*RANK_W +: RANK_W] = r;
  endtask

  function automatic logic [ADDR_W-1:0] exp_seed(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] s = '0;
    for (int k = 0; k < ADDR_W; k++) begin
      if (k > HI_HI && k <= HI_HI + UNMASK_N) s[k] = b[k];
      else if (k >= HI_LO && k <= HI_HI) s[k] = b[k] & ~m[k];
      else if (fctr > 1 && k >= LO_LO && k <= LO_HI) s[k] = b[k] & ~m[k];
    end
    return s;
  endfunction

  task automatic model(input logic [RANK_W-1:0] r, output logic [1:0] e,
                       output logic [ADDR_W-1:0] s, output int lat);
    int m = -1, b = -1;
    e = 2'd0; s = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (m < 0 && t_rank[i*RANK_W +: RANK_W] == r) m = i;
    if (m < 0) begin e = 2'd1; lat = NUM_CS; return; end
    lat = m + 1;
    if (bad != ABS && t_num[m*NUM_W +: NUM_W] == bad) begin e = 2'd1; return; end
    if (t_fail[m]) begin e = 2'd1; return; end
    if (spare != ABS && bad != ABS && t_num[m*NUM_W +: NUM_W] == spare) begin
      for (int i = 0; i < NUM_CS; i++)
        if (b < 0 && t_num[i*NUM_W +: NUM_W] == bad) b = i;
      if (b < 0) begin e = 2'd2; lat = m + 1 + NUM_CS; return; end
      lat = m + 2 + b;
      s = exp_seed(t_base[b*ADDR_W +: ADDR_W], t_mask[b*ADDR_W +: ADDR_W]);
      return;
    end
    s = exp_seed(t_base[m*ADDR_W +: ADDR_W], t_mask[m*ADDR_W +: ADDR_W]);
  endtask

  // restart: pulse start with another rank one cycle into the scan
  task automatic run(input logic [RANK_W-1:0] r, input string tag, input bit restart);
    logic [1:0] ee; logic [ADDR_W-1:0] es; int el, l;
    model(r, ee, es, el);
    @(negedge clk); req_rank = r; start = 1;
    @(negedge clk); start = 0;
    l = 0;
    if (restart) begin
      req_rank = ~r; start = 1;
      @(negedge clk); start = 0; l = 1;
    end
    while (!done && l < 4 * NUM_CS) begin @(negedge clk); l++; end
    chk(done === 1'b1, {tag, " done"}, 64'(done), 64'd1);
    chk(err === ee, {tag, " err"}, 64'(err), 64'(ee));
    chk(seed === es, {tag, " seed"}, 64'(seed), 64'(es));
    chk(l == el, {tag, " R11 latency"}, 64'(l), 64'(el));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R11 pulse"}, 64'(done), 64'd0);
    chk(err === ee && seed === es, {tag, " R12 hold"}, 64'(err), 64'(ee));
  endtask

  task automatic base_table();
    for (int i = 0; i < NUM_CS; i++)
      set_ent(i, NUM_W'(i), {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, RANK_W'(i));
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    chk(done === 0 && err === 0 && seed === 0, "R12 reset", 64'(seed), 64'd0);
    rst_n = 1;
    @(negedge clk);

    base_table();
    set_ent(3, 4'd3, 36'hF_FFFF_FFFF, 36'h0_0AAA_0AA0, 1'b0, 3'd3);
    fctr = 4'd1; run(3'd3, "R1 R7 R9 plain", 0);
    fctr = 4'd0; run(3'd3, "R8 fctr0", 0);
    fctr = 4'd2; run(3'd3, "R8 lo on", 0);
    fctr = 4'd0;
    set_ent(5, 4'd5, 36'h3_ABCD_1234, 36'h0_0000_0000, 1'b0, 3'd3);
    run(3'd3, "R1 first dup", 0);
    run(3'd7, "R2 no match", 0);
    bad = 4'd2; run(3'd2, "R3 bad", 0);
    bad = ABS;  set_ent(4, 4'd4, 36'h1, 36'h0, 1'b1, 3'd4);
    run(3'd4, "R4 fail", 0);
    bad = 4'd2; spare = 4'd4; set_ent(4, 4'd4, 36'h1, 36'h0, 1'b1, 3'd4);
    run(3'd4, "R4 before R5", 0);
    base_table();
    spare = 4'd1; bad = 4'd6; fctr = 4'd3;
    set_ent(6, 4'd6, 36'hC_5555_AAAA, 36'h0_1111_0F0F, 1'b1, 3'd6);
    run(3'd1, "R5 spare", 0);
    bad = 4'd11; run(3'd1, "R6 miss", 0);
    bad = ABS; run(3'd1, "R10 bad absent", 0);
    spare = ABS; bad = 4'd9; set_ent(2, ABS, 36'hF_0000_0000, 36'h0, 1'b0, 3'd2);
    run(3'd2, "R10 allones num", 0);
    spare = ABS; bad = ABS;
    run(3'd7, "R11 restart ignored", 1);
    run(3'd6, "R11 restart ignored late", 1);

    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < NUM_CS; i++)
        set_ent(i, NUM_W'($urandom % 12), {$urandom, $urandom}, {$urandom, $urandom},
                ($urandom % 6) == 0, RANK_W'($urandom % 6));
      spare = ($urandom % 3 == 0) ? ABS : NUM_W'($urandom % 12);
      bad   = ($urandom % 3 == 0) ? ABS : NUM_W'($urandom % 14);
      fctr  = FCTR_W'($urandom % 4);
      run(RANK_W'($urandom), "R1 R5 random", 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule